// File: doc/BRIEF.md
# Paged Word Address Counter

This block keeps the 9-bit internal word address of a 512-byte serial memory. The memory is arranged as 32 pages of 16 bytes. The serial front end loads the address in two steps. The most significant bit arrives as the page bit inside the device address byte. The remaining eight bits arrive later as a separate word address byte. Each of the two loads has its own strobe.

After each data byte the front end pulses a step strobe, and the counter advances in one of two ways. In write mode only the offset within the page moves: the offset wraps from 15 back to 0, and the page number does not change. In read mode the whole 9-bit address counts up and wraps from 511 back to 0.

When no strobe is pulsed, the register holds its value. Between transfers it therefore keeps the last accessed location plus one, which is what a current-address read needs. A write-allowed flag is derived from a protect input and the address. It shuts out only the upper half of the array. It never stalls the counter.

Top module: `wac_addr_ctr`

## Requirements
- R1: While the synchronous active-low reset is low at a rising clock edge, the address becomes 0 after that edge.
- R2: A page load strobe copies the page bit into address bit 8 and leaves bits 7..0 unchanged.
- R3: A word load strobe copies the 8-bit word value into address bits 7..0 and leaves bit 8 unchanged.
- R4: A step with the mode input low (0 = write mode) increments only bits 3..0 modulo 16. Bits 8..4 keep their value, so offset 15 is followed by offset 0 of the same page.
- R5: A step with the mode input high (1 = read mode) increments the full 9-bit address modulo 512, so 511 is followed by 0.
- R6: In a cycle with no load strobe and no step, the address keeps its value, including the value left by the last step of a previous transfer.
- R7: The write-allowed output is low exactly when the protect input is high and address bit 8 is 1. It is high in every other case, without waiting for a clock edge.
- R8: If any load strobe is high in a cycle, the step strobe is ignored in that cycle. Bits that the active loads do not cover keep their value.
- R9: A step advances the address even when the write-allowed output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| page_ld | input | 1 | Load strobe for address bit 8 |
| page_bit | input | 1 | Page bit taken from the device address byte |
| word_ld | input | 1 | Load strobe for address bits 7..0 |
| word_byte | input | 8 | Received word address byte |
| step | input | 1 | Advance the address by one byte |
| rd_mode | input | 1 | Step mode: 0 = wrap within page, 1 = wrap across array |
| wp_in | input | 1 | Protect input; high shields the upper half |
| addr | output | 9 | Current word address |
| wr_ok | output | 1 | Write to current address is permitted |

## Verification
Every one of the 512 addresses is loaded and then stepped once in write mode and once in read mode. This separates a page-local wrap from a full-array carry at every page boundary, and exposes a carry that leaks into the page bits. Each of the two loads is applied alone over alternating patterns, which shows whether it disturbs the bits it does not own. Load and step are applied together to confirm the priority of the load. The protect input is swept against both halves of the array, and a step is taken while writes are blocked. Idle cycles after a run of steps show that the last address plus one is kept.

// File: rtl/wac_pkg.sv
// Package: shared definitions for the paged word address counter.
// Assumes: mode input encodes 0 = write (page wrap), 1 = read (array wrap).
package wac_pkg;
    typedef enum logic {
        WAC_WRITE = 1'b0,
        WAC_READ  = 1'b1
    } wac_mode_e;
endpackage

// File: rtl/wac_load_mux.sv
// Module: wac_load_mux
// Merges the two partial address loads into one load value.
// Assumes the top bit belongs to the page load and the rest to the word load.
module wac_load_mux #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              page_ld,
    input  logic              page_bit,
    input  logic              word_ld,
    input  logic [ADDR_W-2:0] word_byte,
    output logic [ADDR_W-1:0] ld_val,
    output logic              any_ld
);
    // Build the loaded value: each field is taken from its source or kept.
    always_comb begin
        ld_val[ADDR_W-1]   = page_ld ? page_bit : cur[ADDR_W-1];
        ld_val[ADDR_W-2:0] = word_ld ? word_byte : cur[ADDR_W-2:0];
        any_ld             = page_ld | word_ld;
    end
endmodule

// File: rtl/wac_stepper.sv
// Module: wac_stepper
// Computes the next address after one byte in either wrap mode.
// Assumes OFS_W < ADDR_W; the page number is the bits above the offset.
module wac_stepper
    import wac_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int OFS_W  = 4
) (
    input  logic [ADDR_W-1:0] cur,
    input  wac_mode_e         mode,
    output logic [ADDR_W-1:0] nxt
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] full_inc;
    logic [ADDR_W-1:0] page_inc;
    logic [OFS_W-1:0]  ofs_inc;

    // Full-array increment, natural modulo 2**ADDR_W wrap.
    always_comb full_inc = cur + 1'b1;

    // Offset-only increment, wraps inside the page.
    always_comb ofs_inc = cur[OFS_W-1:0] + 1'b1;

    // Reassemble the page-local result; a page field exists only if PAGE_W > 0.
    generate
        if (PAGE_W > 0) begin : g_paged
            always_comb page_inc = {cur[ADDR_W-1:OFS_W], ofs_inc};
        end else begin : g_flat
            always_comb page_inc = ofs_inc;
        end
    endgenerate

    // Select by mode.
    always_comb nxt = (mode == WAC_READ) ? full_inc : page_inc;
endmodule

// File: rtl/wac_protect.sv
// Module: wac_protect
// Write qualification: the upper half of the array is shielded when the
// protect input is high. Combinational; it never gates the counter.
module wac_protect (
    input  logic wp_in,
    input  logic upper_half,
    output logic wr_ok
);
    // Permit unless protection is on and the address is in the upper half.
    always_comb wr_ok = ~(wp_in & upper_half);
endmodule

// File: rtl/wac_addr_ctr.sv
// Module: wac_addr_ctr (top)
// Holds the word address of a paged serial memory, loads it from the page
// bit and the word byte, steps it per mode, and flags permitted writes.
// Assumes strobes are single-cycle and already synchronous to clk.
module wac_addr_ctr
    import wac_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_ld,
    input  logic              page_bit,
    input  logic              word_ld,
    input  logic [ADDR_W-2:0] word_byte,
    input  logic              step,
    input  logic              rd_mode,
    input  logic              wp_in,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_ok
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] ld_val;
    logic [ADDR_W-1:0] step_val;
    logic [ADDR_W-1:0] addr_d;
    logic              any_ld;
    wac_mode_e         mode;

    // Interpret the raw mode pin.
    always_comb mode = wac_mode_e'(rd_mode);

    wac_load_mux #(.ADDR_W(ADDR_W)) u_ld (
        .cur       (addr_q),
        .page_ld   (page_ld),
        .page_bit  (page_bit),
        .word_ld   (word_ld),
        .word_byte (word_byte),
        .ld_val    (ld_val),
        .any_ld    (any_ld)
    );

    wac_stepper #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_step (
        .cur  (addr_q),
        .mode (mode),
        .nxt  (step_val)
    );

    wac_protect u_prot (
        .wp_in      (wp_in),
        .upper_half (addr_q[ADDR_W-1]),
        .wr_ok      (wr_ok)
    );

    // Next-state priority: any load, then step, then hold.
    always_comb begin
        if (any_ld)    addr_d = ld_val;
        else if (step) addr_d = step_val;
        else           addr_d = addr_q;
    end

    // Address register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/wac_addr_ctr_chk.sv
// Module: wac_addr_ctr_chk
// Property checker bound to wac_addr_ctr; observes ports only.
module wac_addr_ctr_chk #(
    parameter int ADDR_W = 9,
    parameter int OFS_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              page_ld,
    input logic              page_bit,
    input logic              word_ld,
    input logic [ADDR_W-2:0] word_byte,
    input logic              step,
    input logic              rd_mode,
    input logic              wp_in,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_ok
);
    localparam int MSB = ADDR_W - 1;

    logic idle, w_step, r_step;
    // Classify the cycle's strobes.
    always_comb begin
        idle   = !page_ld && !word_ld && !step;
        w_step = !page_ld && !word_ld && step && !rd_mode;
        r_step = !page_ld && !word_ld && step && rd_mode;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> addr == '0);

    a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        page_ld |=> addr[MSB] == $past(page_bit));

    a_r3_word_load: assert property (@(posedge clk) disable iff (!rst_n)
        word_ld |=> addr[MSB-1:0] == $past(word_byte));

    a_r4_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        w_step |=> addr[MSB:OFS_W] == $past(addr[MSB:OFS_W]));

    a_r4_ofs_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        w_step |=> addr[OFS_W-1:0] == OFS_W'($past(addr[OFS_W-1:0]) + 1'b1));

    a_r5_full_inc: assert property (@(posedge clk) disable iff (!rst_n)
        r_step |=> addr == ADDR_W'($past(addr) + 1'b1));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(addr));

    a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_in && addr[MSB]) |-> !wr_ok);

    a_r7_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_in || !addr[MSB]) |-> wr_ok);

    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (page_ld && !word_ld && step) |=> addr[MSB-1:0] == $past(addr[MSB-1:0]));

    a_r9_step_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (r_step && !wr_ok) |=> addr != $past(addr));
endmodule

bind wac_addr_ctr wac_addr_ctr_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_bit(page_bit),
    .word_ld(word_ld), .word_byte(word_byte), .step(step), .rd_mode(rd_mode),
    .wp_in(wp_in), .addr(addr), .wr_ok(wr_ok)
);

// File: tb/sim_wac_addr_ctr.sv
module sim_wac_addr_ctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       page_ld = 1'b0, page_bit = 1'b0, word_ld = 1'b0, step = 1'b0;
    logic       rd_mode = 1'b0, wp_in = 1'b0;
    logic [7:0] word_byte = 8'h00;
    logic [8:0] addr;
    logic       wr_ok;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    wac_addr_ctr u0 (
        .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_bit(page_bit),
        .word_ld(word_ld), .word_byte(word_byte), .step(step),
        .rd_mode(rd_mode), .wp_in(wp_in), .addr(addr), .wr_ok(wr_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock with given strobes; returns 1 ns after the edge.
    task automatic cyc(input logic pl, input logic pb, input logic wl,
                       input logic [7:0] wb, input logic st, input logic rm);
        @(negedge clk);
        page_ld = pl; page_bit = pb; word_ld = wl; word_byte = wb;
        step = st; rd_mode = rm;
        @(posedge clk); #1;
        page_ld = 1'b0; word_ld = 1'b0; step = 1'b0;
    endtask

    task automatic load(input int a);
        cyc(1'b1, a[8], 1'b1, a[7:0], 1'b0, 1'b0);
    endtask

    initial begin
        int a;
        // R1: reset
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R1", addr, 0);
        load(9'h1A5);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", addr, 0);
        @(negedge clk); rst_n = 1'b1;

        // R4 / R5: every start address in both modes
        for (int s = 0; s < 512; s++) begin
            load(s);
            cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
            chk("R4", addr, (s & 9'h1F0) | ((s + 1) & 4'hF));
            load(s);
            cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
            chk("R5", addr, (s + 1) % 512);
        end

        // R2 / R3: separate loads keep the other field
        for (int s = 0; s < 512; s += 37) begin
            load(s);
            cyc(1'b1, ~s[8], 1'b0, 8'h00, 1'b0, 1'b0);
            chk("R2", addr, s ^ 256);
            cyc(1'b0, 1'b0, 1'b1, ~s[7:0], 1'b0, 1'b0);
            chk("R3", addr, (s & 256) ^ 256 | (~s & 255));
        end

        // R8: load beats step
        load(9'h0FF);
        cyc(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
        chk("R8", addr, 9'h1FF);
        cyc(1'b0, 1'b0, 1'b1, 8'h10, 1'b1, 1'b0);
        chk("R8", addr, 9'h110);

        // R6: run of write steps, then idle cycles keep last+1
        load(9'h13E);
        for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6", addr, 9'h133);

        // R7: protect sweep over both halves
        for (int s = 0; s < 512; s += 31) begin
            load(s);
            for (int w = 0; w < 2; w++) begin
                @(negedge clk); wp_in = w[0]; #1;
                chk("R7", wr_ok, (w == 1 && s >= 256) ? 0 : 1);
            end
        end

        // R9: stepping while writes are blocked
        @(negedge clk); wp_in = 1'b1;
        load(9'h1F0);
        chk("R9", wr_ok, 0);
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R9", addr, 9'h1F1);
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        chk("R9", addr, 9'h1F2);
        a = addr;
        chk("R6", a, 9'h1F2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule